// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator. The accumulator lives in two 32-bit registers, an upper half and a lower half, which are read back on separate ports. A request strobe starts one accumulate step. The result is registered at the next clock edge, and a one-cycle completion pulse marks it.

A mode input chooses the operand size. In long mode the full 32-bit operands are multiplied. In word mode only the low 16 bits of each operand are multiplied. A saturation input chooses between plain wrap-around and clamping, and the clamp works differently in each mode. Long mode confines the upper half to a 48-bit signed span. Word mode clamps the lower half to the signed 32-bit range and leaves the upper half unclamped.

A clear strobe and two half-width load ports let the surrounding logic set the accumulator directly. The clear strobe wins over a load, and a load wins over an accumulate in the same cycle.

Top module: `sat_mac`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_hi`, `acc_lo` and `done` become zero.
- R2: Long mode (`op_word`=0) with `sat_en`=0: the signed 32x32 product of `op_a` and `op_b` is added to the 64-bit value {`acc_hi`,`acc_lo`}. The sum wraps modulo 2^64, and its upper and lower 32 bits go to `acc_hi` and `acc_lo` at the next edge.
- R3: Word mode (`op_word`=1) with `sat_en`=0: only bits 15:0 of each operand are used, read as signed. Their product is sign-extended to 64 bits and accumulated with wrap-around. Bits 31:16 of the operands have no effect.
- R4: Long mode with `sat_en`=1: `acc_lo` takes the raw low 32 bits of the sum. If bit 63 of the sum is set, `acc_hi` takes the raw upper word with bits 31:16 forced to ones. Otherwise `acc_hi` keeps only bits 14:0 of the raw upper word, and bits 31:15 become zero.
- R5: Word mode with `sat_en`=1: a sum below -2^31 gives `acc_lo`=0x80000000, and a sum above 2^31-1 gives `acc_lo`=0x7FFFFFFF. `acc_hi` always takes the raw upper 32 bits of the sum. A sum inside the range is stored unchanged.
- R6: `clr` high at an edge zeroes both halves. It overrides any load and any accumulate in the same cycle.
- R7: `ld_hi_en` and `ld_lo_en` each write their own half independently. Any load in a cycle suppresses an accumulate requested in that cycle, and a half that is not loaded keeps its value.
- R8: `done` is high for exactly the cycle after an accepted accumulate (`op_valid` high with no clear and no load), with the updated halves visible at the same time. In every other cycle `done` is low.
- R9: A cycle with no request, clear or load leaves both halves unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accumulate request strobe |
| op_word | input | 1 | Mode: 0 long (32x32), 1 word (16x16) |
| sat_en | input | 1 | Saturating accumulation when high |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| clr | input | 1 | Zero the accumulator |
| ld_hi_en | input | 1 | Load the upper half |
| ld_hi_data | input | 32 | Value for the upper half |
| ld_lo_en | input | 1 | Load the lower half |
| ld_lo_data | input | 32 | Value for the lower half |
| acc_hi | output | 32 | Upper accumulator half |
| acc_lo | output | 32 | Lower accumulator half |
| done | output | 1 | Result-valid pulse |

## Verification
An accumulate request can land in the same cycle as a clear or a load. This collision is the case where the priority order decides the result. The bench raises `op_valid` together with `clr`, then together with a load of only the upper half, then together with a load of only the lower half. A behavioural 64-bit model predicts the outcome of each case: zero after a clear, and after a load the loaded half new, the other half unchanged and `done` low. The outputs are compared with the model on every clock.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef enum logic {
    MODE_LONG = 1'b0,
    MODE_WORD = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/sat_mac_mult.sv
module sat_mac_mult
  import sat_mac_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int WORD_W = 16
) (
  input  logic [HALF_W-1:0]   op_a,
  input  logic [HALF_W-1:0]   op_b,
  input  mac_mode_e           mode,
  output logic [2*HALF_W-1:0] prod
);
  localparam int ACC_W = 2 * HALF_W;

  logic [ACC_W-1:0] a_ext, b_ext;

  // Sign-extend the selected operand width to the accumulator width; the low
  // ACC_W bits of the product are then the correct two's-complement result.
  always_comb begin
    if (mode == MODE_WORD) begin
      a_ext = {{(ACC_W-WORD_W){op_a[WORD_W-1]}}, op_a[WORD_W-1:0]};
      b_ext = {{(ACC_W-WORD_W){op_b[WORD_W-1]}}, op_b[WORD_W-1:0]};
    end else begin
      a_ext = {{(ACC_W-HALF_W){op_a[HALF_W-1]}}, op_a};
      b_ext = {{(ACC_W-HALF_W){op_b[HALF_W-1]}}, op_b};
    end
  end

  assign prod = a_ext * b_ext;
endmodule

// File: rtl/sat_mac_sat.sv
module sat_mac_sat
  import sat_mac_pkg::*;
#(
  parameter int HALF_W     = 32,
  parameter int SAT_SPAN_W = 48
) (
  input  logic [2*HALF_W-1:0] sum,
  input  mac_mode_e           mode,
  input  logic                sat_en,
  output logic [HALF_W-1:0]   res_hi,
  output logic [HALF_W-1:0]   res_lo
);
  localparam int ACC_W  = 2 * HALF_W;
  localparam int ONES_W = ACC_W - SAT_SPAN_W;       // upper bits forced on negative
  localparam int KEEP_W = SAT_SPAN_W - HALF_W - 1;  // low bits kept on non-negative
  localparam logic [HALF_W-1:0] OR_MASK  = {{ONES_W{1'b1}}, {(HALF_W-ONES_W){1'b0}}};
  localparam logic [HALF_W-1:0] AND_MASK = {{(HALF_W-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};
  localparam logic [HALF_W-1:0] LO_MIN   = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] LO_MAX   = {1'b0, {(HALF_W-1){1'b1}}};

  logic [HALF_W-1:0] raw_hi, raw_lo;
  logic [HALF_W:0]   top_bits;
  logic              neg_ovf, pos_ovf;

  assign raw_hi   = sum[ACC_W-1:HALF_W];
  assign raw_lo   = sum[HALF_W-1:0];
  // The sum fits a signed half word only if bits ACC_W-1 .. HALF_W-1 all match.
  assign top_bits = sum[ACC_W-1:HALF_W-1];
  assign neg_ovf  = sum[ACC_W-1] & ~(&top_bits);
  assign pos_ovf  = ~sum[ACC_W-1] & (|top_bits);

  always_comb begin
    res_hi = raw_hi;
    res_lo = raw_lo;
    if (sat_en) begin
      if (mode == MODE_LONG) begin
        if (sum[ACC_W-1]) res_hi = raw_hi | OR_MASK;
        else              res_hi = raw_hi & AND_MASK;
      end else begin
        if (neg_ovf)      res_lo = LO_MIN;
        else if (pos_ovf) res_lo = LO_MAX;
      end
    end
  end
endmodule

// File: rtl/sat_mac_acc.sv
module sat_mac_acc #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ld_hi_en,
  input  logic [HALF_W-1:0] ld_hi_data,
  input  logic              ld_lo_en,
  input  logic [HALF_W-1:0] ld_lo_data,
  input  logic              op_valid,
  input  logic [HALF_W-1:0] new_hi,
  input  logic [HALF_W-1:0] new_lo,
  output logic [HALF_W-1:0] acc_hi,
  output logic [HALF_W-1:0] acc_lo,
  output logic              done
);
  logic any_ld, accept;

  assign any_ld = ld_hi_en | ld_lo_en;
  assign accept = op_valid & ~clr & ~any_ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi <= '0;
      acc_lo <= '0;
      done   <= 1'b0;
    end else begin
      done <= accept;
      if (clr) begin
        acc_hi <= '0;
        acc_lo <= '0;
      end else if (any_ld) begin
        if (ld_hi_en) acc_hi <= ld_hi_data;
        if (ld_lo_en) acc_lo <= ld_lo_data;
      end else if (op_valid) begin
        acc_hi <= new_hi;
        acc_lo <= new_lo;
      end
    end
  end

  // R6: clear wins over everything
  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_hi == '0) && (acc_lo == '0));

  // R7: an upper-half load lands even with a request in the same cycle
  a_r7_load_hi: assert property (@(posedge clk) disable iff (rst)
    (ld_hi_en && !clr) |=> acc_hi == $past(ld_hi_data));

  // R7: a lower-half load alone leaves the upper half untouched
  a_r7_load_lo_only: assert property (@(posedge clk) disable iff (rst)
    (ld_lo_en && !ld_hi_en && !clr) |=> (acc_lo == $past(ld_lo_data)) && $stable(acc_hi));

  // R8: done follows an accepted request and nothing else
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !clr && !ld_hi_en && !ld_lo_en) |=> done);
  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && !clr && !ld_hi_en && !ld_lo_en) |=> !done);

  // R9: idle cycles hold the accumulator
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !clr && !ld_hi_en && !ld_lo_en) |=> $stable(acc_hi) && $stable(acc_lo));
endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import sat_mac_pkg::*;
#(
  parameter int HALF_W     = 32,
  parameter int WORD_W     = 16,
  parameter int SAT_SPAN_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_word,
  input  logic              sat_en,
  input  logic [HALF_W-1:0] op_a,
  input  logic [HALF_W-1:0] op_b,
  input  logic              clr,
  input  logic              ld_hi_en,
  input  logic [HALF_W-1:0] ld_hi_data,
  input  logic              ld_lo_en,
  input  logic [HALF_W-1:0] ld_lo_data,
  output logic [HALF_W-1:0] acc_hi,
  output logic [HALF_W-1:0] acc_lo,
  output logic              done
);
  localparam int ACC_W  = 2 * HALF_W;
  localparam int ONES_W = ACC_W - SAT_SPAN_W;
  localparam int KEEP_W = SAT_SPAN_W - HALF_W - 1;

  mac_mode_e         mode;
  logic [ACC_W-1:0]  prod, sum;
  logic [HALF_W-1:0] sat_hi, sat_lo;

  assign mode = op_word ? MODE_WORD : MODE_LONG;

  sat_mac_mult #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_mult (
    .op_a (op_a),
    .op_b (op_b),
    .mode (mode),
    .prod (prod)
  );

  assign sum = {acc_hi, acc_lo} + prod;

  sat_mac_sat #(.HALF_W(HALF_W), .SAT_SPAN_W(SAT_SPAN_W)) u_sat (
    .sum    (sum),
    .mode   (mode),
    .sat_en (sat_en),
    .res_hi (sat_hi),
    .res_lo (sat_lo)
  );

  sat_mac_acc #(.HALF_W(HALF_W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .ld_hi_en   (ld_hi_en),
    .ld_hi_data (ld_hi_data),
    .ld_lo_en   (ld_lo_en),
    .ld_lo_data (ld_lo_data),
    .op_valid   (op_valid),
    .new_hi     (sat_hi),
    .new_lo     (sat_lo),
    .acc_hi     (acc_hi),
    .acc_lo     (acc_lo),
    .done       (done)
  );

  // R4: a saturating long-mode step leaves the upper half inside the span
  a_r4_long_span: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_word && sat_en && !clr && !ld_hi_en && !ld_lo_en) |=>
      (acc_hi[HALF_W-1 -: ONES_W] == '1) || (acc_hi[HALF_W-1:KEEP_W] == '0));

  // R2: a zero operand in wrap-around long mode leaves the value unchanged
  a_r2_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_word && !sat_en && (op_a == '0) && !clr && !ld_hi_en && !ld_lo_en) |=>
      $stable(acc_hi) && $stable(acc_lo));
endmodule

// File: tb/sat_mac_test.sv
module sat_mac_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0, op_word = 1'b0, sat_en = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        clr = 1'b0, ld_hi_en = 1'b0, ld_lo_en = 1'b0;
  logic [31:0] ld_hi_data = '0, ld_lo_data = '0;
  logic [31:0] acc_hi, acc_lo;
  logic        done;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    started  = 0;
  bit    finished = 0;
  string cur_req  = "R1";

  logic [31:0] m_hi = '0, m_lo = '0;
  logic        m_done = 1'b0;

  always #4 clk = ~clk;

  sat_mac uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word), .sat_en(sat_en),
    .op_a(op_a), .op_b(op_b), .clr(clr), .ld_hi_en(ld_hi_en), .ld_hi_data(ld_hi_data),
    .ld_lo_en(ld_lo_en), .ld_lo_data(ld_lo_data), .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
  );

  // Behavioural reference: 64-bit signed integer arithmetic
  always @(posedge clk) begin
    longint acc, prod, s;
    int     sa, sb;
    shortint wa, wb;
    started <= 1'b1;
    if (rst || clr) begin
      m_hi = '0; m_lo = '0; m_done = 1'b0;
    end else if (ld_hi_en || ld_lo_en) begin
      if (ld_hi_en) m_hi = ld_hi_data;
      if (ld_lo_en) m_lo = ld_lo_data;
      m_done = 1'b0;
    end else if (op_valid) begin
      acc = longint'({m_hi, m_lo});
      if (op_word) begin
        wa = shortint'(op_a[15:0]); wb = shortint'(op_b[15:0]);
        prod = longint'(wa) * longint'(wb);
      end else begin
        sa = int'(op_a); sb = int'(op_b);
        prod = longint'(sa) * longint'(sb);
      end
      s = acc + prod;
      m_hi = s[63:32];
      m_lo = s[31:0];
      if (sat_en && !op_word) begin
        if (s < 0) m_hi = m_hi | 32'hFFFF0000;
        else       m_hi = m_hi & 32'h00007FFF;
      end else if (sat_en && op_word) begin
        if (s < -64'sd2147483648)    m_lo = 32'h80000000;
        else if (s > 64'sd2147483647) m_lo = 32'h7FFFFFFF;
      end
      m_done = 1'b1;
    end else begin
      m_done = 1'b0;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (started && !finished) begin
      n_checks++;
      if (acc_hi !== m_hi || acc_lo !== m_lo || done !== m_done) begin
        n_fail++;
        $display("FAIL %s: got hi=%08h lo=%08h done=%0b expected hi=%08h lo=%08h done=%0b",
                 cur_req, acc_hi, acc_lo, done, m_hi, m_lo, m_done);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    op_valid = 0; clr = 0; ld_hi_en = 0; ld_lo_en = 0;
  endtask

  task automatic mac(input bit word, input bit sat, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1; op_word = word; sat_en = sat; op_a = a; op_b = b;
    clr = 0; ld_hi_en = 0; ld_lo_en = 0;
  endtask

  task automatic load(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    op_valid = 0; clr = 0;
    ld_hi_en = 1; ld_hi_data = hi; ld_lo_en = 1; ld_lo_data = lo;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1"; idle(); rst = 0; idle();

    cur_req = "R2";
    mac(0, 0, 32'd1000, 32'd2000);
    mac(0, 0, 32'hFFFFFFFF, 32'd7);
    mac(0, 0, 32'h80000000, 32'h80000000);
    mac(0, 0, 32'h80000000, 32'h7FFFFFFF);
    mac(0, 0, 32'd0, 32'h12345678);
    for (int i = 0; i < 40; i++) mac(0, 0, $urandom, $urandom);
    load(32'hFFFFFFFF, 32'hFFFFFFFF);
    mac(0, 0, 32'd1, 32'd1);                       // wrap to zero
    idle();

    cur_req = "R3";
    load(32'h0, 32'h0);
    mac(1, 0, 32'hABCD0003, 32'h1234FFFE);         // 3 * -2, upper bits junk
    mac(1, 0, 32'h00008000, 32'h00008000);         // -32768 squared
    for (int i = 0; i < 40; i++) mac(1, 0, $urandom, $urandom);
    idle();

    cur_req = "R4";
    load(32'h00007FFF, 32'hFFFFFFF0);              // just under 2^47
    mac(0, 1, 32'd16, 32'd2);                      // crosses 2^47
    load(32'hFFFF8000, 32'h00000010);              // near -2^47
    mac(0, 1, 32'hFFFFFFFF, 32'd64);
    load(32'h00001234, 32'h0);
    mac(0, 1, 32'd3, 32'd5);                       // in range
    load(32'h00007FFF, 32'hFFFFFFF0);
    mac(0, 0, 32'd16, 32'd2);                      // same with sat off
    for (int i = 0; i < 30; i++) mac(0, 1, $urandom, $urandom);
    idle();

    cur_req = "R5";
    load(32'h0, 32'h7FFFFFF0);
    mac(1, 1, 32'h00000100, 32'h00000100);         // above 2^31-1
    load(32'hFFFFFFFF, 32'h80000010);
    mac(1, 1, 32'h0000FF00, 32'h00000100);         // below -2^31
    load(32'h0, 32'h7FFFFFF0);
    mac(1, 1, 32'h00000001, 32'h00000001);         // in range
    load(32'h0, 32'h7FFFFFF0);
    mac(1, 0, 32'h00000100, 32'h00000100);         // sat off wraps
    load(32'h00000005, 32'h00000000);
    mac(1, 1, 32'h1, 32'h1);                       // high raw, low clamps
    for (int i = 0; i < 30; i++) mac(1, 1, $urandom, $urandom);
    idle();

    cur_req = "R6";
    load(32'h11111111, 32'h22222222);
    @(negedge clk);
    op_valid = 1; op_word = 0; sat_en = 0; op_a = 5; op_b = 5;
    clr = 1; ld_hi_en = 1; ld_hi_data = 32'hDEADBEEF; ld_lo_en = 1; ld_lo_data = 32'h1;
    idle();

    cur_req = "R7";
    load(32'h00000001, 32'h00000002);
    @(negedge clk);
    op_valid = 1; op_a = 9; op_b = 9; ld_hi_en = 1; ld_hi_data = 32'hCAFE0000; ld_lo_en = 0;
    @(negedge clk);
    op_valid = 1; op_a = 9; op_b = 9; ld_hi_en = 0; ld_lo_en = 1; ld_lo_data = 32'h0000BEEF;
    idle(); idle();

    cur_req = "R8";
    mac(0, 0, 32'd3, 32'd4);
    mac(1, 0, 32'd3, 32'd4);
    idle();
    mac(0, 1, 32'd7, 32'd7);
    idle();

    cur_req = "R9";
    repeat (5) idle();

    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule